// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block decides which of two ports may access a shared RAM word when both ports aim at the same location. Each clock, each port presents an enable, an address and a write request. The block compares the two addresses. When both enables are active on the same address, it declares contention. The port whose enable and address were already in place on the previous clock keeps the location. The other port is shown an active-low busy flag in that same cycle. If neither port can claim to have been first, the left port wins.

A mode strap selects how the block behaves when several RAM slices are built side by side. With the strap high, the block arbitrates and drives the busy flags out. With the strap low, its own busy outputs stay idle and the busy flags arriving from an external arbiter take over. In both modes each port receives a write-grant qualifier. The grant is the port's write request, blocked while that port's busy is active.

Top module: `dp_contention_arbiter`

## Requirements
- R1: With the strap high, a busy output goes low only when both enables are 1 and the two addresses are equal.
- R2: Busy is active low: 0 means busy and 1 means idle. Out of reset, with both enables at 0, both busy outputs read 1.
- R3: When contention begins, a port whose enable was 1 with the same address on the previous clock keeps the location if the other port's was not. The losing port's busy output goes low in the same cycle the match appears. Only one port is ever busy.
- R4: Contention can begin in two ways, and both are handled alike: an address changing to a match while both enables are already 1, or an enable rising while the addresses already match.
- R5: If both ports are new to the match in the same cycle, the left port wins and the right port gets busy. Contention in the first cycle after reset, when there is no history yet, counts as a same-cycle start.
- R6: While contention continues from cycle to cycle, the winner does not change. This holds even if both addresses move together to a new equal value.
- R7: Busy is removed in the first cycle in which the addresses differ or either enable is 0.
- R8: With the strap low, both busy outputs stay at 1, and each port's busy input is used as that port's busy.
- R9: Each write grant equals that port's write request ANDed with NOT that port's busy. In master mode the busy is the one the block computes; in slave mode it is the busy input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| isMaster | input | 1 | Mode strap: 1 arbitrates, 0 follows the busy inputs |
| leftEn | input | 1 | Left port enable, active high |
| leftAddr | input | ADDR_W | Left port word address |
| leftWrReq | input | 1 | Left port write request |
| rightEn | input | 1 | Right port enable, active high |
| rightAddr | input | ADDR_W | Right port word address |
| rightWrReq | input | 1 | Right port write request |
| leftBusyInN | input | 1 | External busy for the left port in slave mode, active low |
| rightBusyInN | input | 1 | External busy for the right port in slave mode, active low |
| leftBusyOutN | output | 1 | Computed busy to the left port, active low |
| rightBusyOutN | output | 1 | Computed busy to the right port, active low |
| leftWrGrant | output | 1 | Left write request qualified by left busy |
| rightWrGrant | output | 1 | Right write request qualified by right busy |

## Verification
The hardest situation to reach from the ports is a held winner that disagrees with what fresh arbitration would pick. This happens when an ongoing match moves: both addresses change to a new equal value in the same cycle. A design that recomputes the winner every cycle would then fall back to the tie-break.

The directed part of the stimulus builds this case first with the right port as the loser. It then builds the mirror case, where the right port wins by steadiness and the match moves with both ports in flight. After the directed part, a long stream follows. In it, addresses are held for several cycles and drawn from a narrow range, so that enable-first starts, address-first starts, tied starts and moving matches all recur under both strap settings.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_LEFT  = 2'd1,
    WIN_RIGHT = 2'd2
  } winner_e;

  // Status that the datapath hands to the control.
  typedef struct packed {
    logic contend;
    logic leftSteady;
    logic rightSteady;
  } match_t;

  // Strobes that the control hands back to the datapath.
  typedef struct packed {
    logic holdLeft;
    logic holdRight;
  } strobe_t;

endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  logic              leftEn,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftWrReq,
  input  logic              rightEn,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightWrReq,
  input  logic              leftBusyInN,
  input  logic              rightBusyInN,
  input  strobe_t           strobe,
  output match_t            matchInfo,
  output logic              leftBusyOutN,
  output logic              rightBusyOutN,
  output logic              leftWrGrant,
  output logic              rightWrGrant
);

  localparam int NPORT = 2;

  logic              curEn   [NPORT];
  logic [ADDR_W-1:0] curAddr [NPORT];
  logic              steady  [NPORT];

  assign curEn[0]   = leftEn;
  assign curEn[1]   = rightEn;
  assign curAddr[0] = leftAddr;
  assign curAddr[1] = rightAddr;

  // Per-port history: was this port enabled on this address last clock?
  for (genvar p = 0; p < NPORT; p++) begin : g_hist
    logic              prevEn;
    logic [ADDR_W-1:0] prevAddr;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevEn   <= 1'b0;
        prevAddr <= '0;
      end else begin
        prevEn   <= curEn[p];
        prevAddr <= curAddr[p];
      end
    end
    assign steady[p] = prevEn && (prevAddr == curAddr[p]);
  end

  always_comb begin
    matchInfo.contend     = leftEn && rightEn && (leftAddr == rightAddr);
    matchInfo.leftSteady  = steady[0];
    matchInfo.rightSteady = steady[1];
  end

  logic effLeftBusy, effRightBusy;

  always_comb begin
    leftBusyOutN  = isMaster ? !strobe.holdLeft  : 1'b1;
    rightBusyOutN = isMaster ? !strobe.holdRight : 1'b1;
    effLeftBusy   = isMaster ? strobe.holdLeft   : !leftBusyInN;
    effRightBusy  = isMaster ? strobe.holdRight  : !rightBusyInN;
    leftWrGrant   = leftWrReq  && !effLeftBusy;
    rightWrGrant  = rightWrReq && !effRightBusy;
  end

  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    !matchInfo.contend |-> (leftBusyOutN && rightBusyOutN));

  p_slave_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !isMaster |-> (leftBusyOutN && rightBusyOutN));

  p_slave_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!isMaster && !leftBusyInN) |-> !leftWrGrant);

  p_master_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && !rightBusyOutN) |-> !rightWrGrant);

endmodule

// File: rtl/arb_control.sv
module arb_control
  import arb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  match_t  matchInfo,
  output strobe_t strobe
);

  winner_e winReg;
  winner_e startWin;
  winner_e curWin;

  always_comb begin
    // Only a port that was steady while the other was not wins outright;
    // every other start goes to the left port.
    startWin = (matchInfo.rightSteady && !matchInfo.leftSteady) ? WIN_RIGHT : WIN_LEFT;
    if (!matchInfo.contend)      curWin = WIN_NONE;
    else if (winReg != WIN_NONE) curWin = winReg;
    else                         curWin = startWin;
    strobe.holdLeft  = (curWin == WIN_RIGHT);
    strobe.holdRight = (curWin == WIN_LEFT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) winReg <= WIN_NONE;
    else       winReg <= curWin;
  end

  p_need_match_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.holdLeft || strobe.holdRight) |-> matchInfo.contend);

  p_one_loser_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.holdLeft, strobe.holdRight}));

  p_held_right_r6: assert property (@(posedge clk) disable iff (!rstN)
    (matchInfo.contend && strobe.holdRight) ##1 matchInfo.contend |-> strobe.holdRight);

  p_held_left_r6: assert property (@(posedge clk) disable iff (!rstN)
    (matchInfo.contend && strobe.holdLeft) ##1 matchInfo.contend |-> strobe.holdLeft);

endmodule

// File: rtl/dp_contention_arbiter.sv
module dp_contention_arbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isMaster,
  input  logic              leftEn,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftWrReq,
  input  logic              rightEn,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightWrReq,
  input  logic              leftBusyInN,
  input  logic              rightBusyInN,
  output logic              leftBusyOutN,
  output logic              rightBusyOutN,
  output logic              leftWrGrant,
  output logic              rightWrGrant
);

  match_t  matchInfo;
  strobe_t strobe;

  arb_datapath #(.ADDR_W(ADDR_W)) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .isMaster     (isMaster),
    .leftEn       (leftEn),
    .leftAddr     (leftAddr),
    .leftWrReq    (leftWrReq),
    .rightEn      (rightEn),
    .rightAddr    (rightAddr),
    .rightWrReq   (rightWrReq),
    .leftBusyInN  (leftBusyInN),
    .rightBusyInN (rightBusyInN),
    .strobe       (strobe),
    .matchInfo    (matchInfo),
    .leftBusyOutN (leftBusyOutN),
    .rightBusyOutN(rightBusyOutN),
    .leftWrGrant  (leftWrGrant),
    .rightWrGrant (rightWrGrant)
  );

  arb_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .matchInfo(matchInfo),
    .strobe   (strobe)
  );

endmodule

// File: tb/test_dp_contention_arbiter.sv
`timescale 1ns/1ps
module test_dp_contention_arbiter;

  localparam int ADDR_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic isMaster = 1'b1;
  logic leftEn = 1'b0, rightEn = 1'b0;
  logic [ADDR_W-1:0] leftAddr = '0, rightAddr = '0;
  logic leftWrReq = 1'b0, rightWrReq = 1'b0;
  logic leftBusyInN = 1'b1, rightBusyInN = 1'b1;
  logic leftBusyOutN, rightBusyOutN, leftWrGrant, rightWrGrant;

  always #2.5 clk = ~clk;

  dp_contention_arbiter #(.ADDR_W(ADDR_W)) i_dp_contention_arbiter (
    .clk(clk), .rstN(rstN), .isMaster(isMaster),
    .leftEn(leftEn), .leftAddr(leftAddr), .leftWrReq(leftWrReq),
    .rightEn(rightEn), .rightAddr(rightAddr), .rightWrReq(rightWrReq),
    .leftBusyInN(leftBusyInN), .rightBusyInN(rightBusyInN),
    .leftBusyOutN(leftBusyOutN), .rightBusyOutN(rightBusyOutN),
    .leftWrGrant(leftWrGrant), .rightWrGrant(rightWrGrant)
  );

  int checks = 0;
  int fails = 0;

  // Reference state built from the requirements.
  bit mPrevLE = 0, mPrevRE = 0;
  int mPrevLA = 0, mPrevRA = 0;
  int mWin = 0; // 0 none, 1 left holds, 2 right holds

  task automatic check(input bit ok, input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit m, input bit le, input int la, input bit re, input int ra,
                      input bit lw, input bit rw, input bit lbi, input bit rbi, input string tag);
    bit contend, stL, stR, busyL, busyR, effL, effR;
    int win;
    logic [1:0] expBusy, expGrant;
    @(negedge clk);
    isMaster = m; leftEn = le; rightEn = re;
    leftAddr = la[ADDR_W-1:0]; rightAddr = ra[ADDR_W-1:0];
    leftWrReq = lw; rightWrReq = rw; leftBusyInN = lbi; rightBusyInN = rbi;
    #1;
    contend = le && re && (la == ra);
    stL = mPrevLE && (mPrevLA == la);
    stR = mPrevRE && (mPrevRA == ra);
    if (!contend) win = 0;
    else if (mWin != 0) win = mWin;
    else win = (stR && !stL) ? 2 : 1;
    busyL = (win == 2);
    busyR = (win == 1);
    expBusy = m ? {!busyL, !busyR} : 2'b11;
    effL = m ? busyL : !lbi;
    effR = m ? busyR : !rbi;
    expGrant = {lw && !effL, rw && !effR};
    check({leftBusyOutN, rightBusyOutN} === expBusy, tag,
          {leftBusyOutN, rightBusyOutN}, expBusy);
    check({leftWrGrant, rightWrGrant} === expGrant, "R9",
          {leftWrGrant, rightWrGrant}, expGrant);
    mPrevLE = le; mPrevLA = la; mPrevRE = re; mPrevRA = ra; mWin = win;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    bit m, le, re, lw, rw, lbi, rbi;
    int la, ra;
    int unsigned x;
    string tag;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R2 reset state, idle
    step(1, 0, 0, 0, 0, 1, 1, 1, 1, "R2");
    // R1 both enabled, no match
    step(1, 1, 2, 1, 5, 1, 1, 1, 1, "R1");
    // R4 address path: right moves onto left's address -> right busy (R3)
    step(1, 1, 2, 1, 2, 1, 1, 1, 1, "R4");
    step(1, 1, 2, 1, 2, 1, 1, 1, 1, "R3");
    // R6 both addresses move together, winner kept
    step(1, 1, 3, 1, 3, 1, 1, 1, 1, "R6");
    // R7 mismatch releases
    step(1, 1, 4, 1, 3, 1, 1, 1, 1, "R7");
    // R4 enable path: left enables on right's address -> left busy
    step(1, 0, 6, 1, 6, 1, 1, 1, 1, "R1");
    step(1, 1, 6, 1, 6, 1, 1, 1, 1, "R4");
    // R6 mirror: right keeps winning while match moves
    step(1, 1, 1, 1, 1, 1, 1, 1, 1, "R6");
    // R7 enable drop
    step(1, 1, 1, 0, 1, 1, 1, 1, 1, "R7");
    // R5 tie: both new in same cycle -> right busy
    step(1, 0, 0, 0, 0, 1, 1, 1, 1, "R1");
    step(1, 1, 7, 1, 7, 1, 1, 1, 1, "R5");
    // R8 slave mode under contention, busy inputs steer grants
    step(0, 1, 7, 1, 7, 1, 1, 0, 1, "R8");
    step(0, 1, 7, 1, 7, 1, 1, 1, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 1, 0, 0, "R8");

    // R5 first cycle after reset with a match present
    @(negedge clk); rstN = 1'b0; leftEn = 1'b0; rightEn = 1'b0;
    @(negedge clk); rstN = 1'b1;
    mPrevLE = 0; mPrevRE = 0; mPrevLA = 0; mPrevRA = 0; mWin = 0;
    step(1, 1, 0, 1, 0, 1, 1, 1, 1, "R5");

    // Long stream with held, narrow-range addresses
    x = 32'h1234_5678;
    la = 0; ra = 0;
    for (int n = 0; n < 6000; n++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      m   = ((n / 500) % 3) != 2;
      le  = x[0] | x[1];
      re  = x[2] | x[3];
      if (x[4]) la = (x[6:5] == 2'b11) ? int'(x[10:8]) : int'(x[9:8]);
      if (x[7]) ra = (x[12:11] == 2'b11) ? int'(x[15:13]) : int'(x[14:13]);
      lw  = x[16]; rw = x[17];
      lbi = x[18] | x[19]; rbi = x[20] | x[21];
      if (!m) tag = "R8";
      else if (le && re && la == ra) tag = "R3";
      else tag = "R7";
      step(m, le, la, re, ra, lw, rw, lbi, rbi, tag);
    end

    finishRun();
  end

endmodule